// File: doc/BRIEF.md
# Analog I/O Card Register Block

This block is the device-side register file of a small analog I/O card. It sits on a simple I/O-port bus that carries byte and word accesses at small offsets from the card's base. Through that bus, software can do the following:

- select an input channel range;
- choose the trigger mode, gain and polarity;
- set two 16-bit DAC output codes;
- drive four digital output lines and read four digital input lines;
- run single software-triggered conversions.

A byte write of any value to offset 0x0 starts one conversion. Software polls a busy flag in a volatile status byte and then fetches the 16-bit result with a word read at the same offset 0x0. The converter is a behavioural stand-in: a fixed-latency counter. At its end it loads a sample formed from the latched channel number and that channel's input port.

Each access carries a width flag. Sixteen-bit registers answer only word accesses, and eight-bit registers answer only byte accesses. Reads return data combinationally in the cycle that the read strobe is high, and they have no side effects.

Top module: `aio_regfile`

## Requirements
- R1: After reset, the following all read 0: the channel byte (0x2), control byte (0x9), configuration byte (0x11), both DAC words (0x4, 0x6) and the result word (0x0). The `dout` and `dac_out` ports are 0, and status bit 7 (busy) is 0.
- R2: A word write to 0x4 or 0x6 stores a 16-bit DAC code. The code for 0x4 drives `dac_out[15:0]` and the code for 0x6 drives `dac_out[31:16]` from the next cycle. A word read at the same offset returns the code.
- R3: The channel byte at 0x2 stores all 8 bits and reads them back. Bits [3:0] are the first channel, which selects the conversion input. Bits [7:4] are the last channel and are only stored.
- R4: A conversion starts on a byte write of any value to 0x0 when control bits [1:0] are 00 and no conversion is running. Status bit 7 reads 1 from the cycle after the write, for exactly CONV_CYCLES cycles (default 16).
- R5: When busy clears, a word read at 0x0 returns (chan_in[ch] + ch) mod 2^16. Here ch is the channel latched at the strobe, and chan_in[ch] is bits [16*ch+15:16*ch] of `chan_in`.
- R6: A strobe that arrives while busy is ignored. It neither extends the busy time nor changes the latched channel.
- R7: The control byte at 0x9 stores bits [1:0] and reads 0 in bits [7:2]. Any nonzero mode makes strobe writes start nothing.
- R8: The configuration byte at 0x11 stores bits [2:0] and reads 0 in bits [7:3]. Bits [1:0] are the gain code for x1, x2, x4 and x8, and bit 2 set means unipolar.
- R9: Status bit 5 mirrors `diff_mode`, and the other status bits other than 7 read 0. When `diff_mode` is 1, the conversion uses channel bits [2:0] only.
- R10: A byte read at 0x3 returns `din` in bits [3:0] with the upper bits 0. A byte write at 0x3 drives `dout` from bits [3:0] in the next cycle.
- R11: An access whose width does not match the register is handled as follows: a write is ignored and a read returns 0. This includes a word write or byte read at 0x0.
- R12: Offsets that are not defined read 0 and ignore writes. The status byte at 0x8 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte offset from card base |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_wdata | input | DATA_W (16) | Write data (byte writes use [7:0]) |
| bus_rdata | output | DATA_W (16) | Read data, valid while bus_rd is high, else 0 |
| diff_mode | input | 1 | Input mode strap, 1 = differential |
| chan_in | input | 16*DATA_W | Per-channel sample sources, channel k at [16k+15:16k] |
| din | input | DIO_W (4) | Digital input lines |
| dout | output | DIO_W (4) | Digital output lines |
| dac_out | output | NUM_DAC*DATA_W | DAC codes, channel k at [16k+15:16k] |

## Verification
A busy flag or count that is wrong shows up at the status byte: the bench reads it in the last busy cycle and then in the first idle cycle. A start that is off by one cycle, or a strobe accepted while busy, therefore fails within one read. A wrong latched channel, a wrong mode gate or a wrong wrap of the sum shows up in the result word read straight after busy clears. A decoder that accepts the wrong width or offset corrupts a register that is read back a few cycles later, or corrupts the `dout` or `dac_out` ports in the very next cycle.

// File: rtl/aio_pkg.sv
package aio_pkg;

    // Byte offsets from the card base; software depends on these values.
    localparam logic [7:0] OFF_DATA     = 8'h00;  // strobe (byte wr) / result (word rd)
    localparam logic [7:0] OFF_CHAN     = 8'h02;
    localparam logic [7:0] OFF_DIO      = 8'h03;
    localparam logic [7:0] OFF_DAC_BASE = 8'h04;
    localparam logic [7:0] OFF_STATUS   = 8'h08;
    localparam logic [7:0] OFF_CTRL     = 8'h09;
    localparam logic [7:0] OFF_CFG      = 8'h11;

    localparam int DAC_STRIDE = 2;
    localparam int CHAN_SEL_W = 4;
    localparam int CH_COUNT   = 1 << CHAN_SEL_W;
    localparam int CTRL_W     = 2;
    localparam int CFG_W      = 3;

    localparam logic [CTRL_W-1:0] MODE_SOFT = '0;

    // Status bit positions read by software.
    localparam int ST_BUSY_BIT = 7;
    localparam int ST_DIFF_BIT = 5;

    typedef struct packed {
        logic wr_strobe;
        logic wr_chan;
        logic wr_dio;
        logic wr_ctrl;
        logic wr_cfg;
        logic rd_result;
        logic rd_chan;
        logic rd_dio;
        logic rd_status;
        logic rd_ctrl;
        logic rd_cfg;
    } aio_sel_t;

endpackage

// File: rtl/aio_addr_decode.sv
module aio_addr_decode
    import aio_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int NUM_DAC = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic               rd,
    input  logic               word,
    output aio_sel_t           sel,
    output logic [NUM_DAC-1:0] dac_wr,
    output logic [NUM_DAC-1:0] dac_rd
);

    logic byte_wr, byte_rd, word_wr, word_rd;

    always_comb begin
        byte_wr = wr && !word;
        byte_rd = rd && !word;
        word_wr = wr && word;
        word_rd = rd && word;

        sel           = '0;
        sel.wr_strobe = byte_wr && (addr == ADDR_W'(OFF_DATA));
        sel.wr_chan   = byte_wr && (addr == ADDR_W'(OFF_CHAN));
        sel.wr_dio    = byte_wr && (addr == ADDR_W'(OFF_DIO));
        sel.wr_ctrl   = byte_wr && (addr == ADDR_W'(OFF_CTRL));
        sel.wr_cfg    = byte_wr && (addr == ADDR_W'(OFF_CFG));
        sel.rd_result = word_rd && (addr == ADDR_W'(OFF_DATA));
        sel.rd_chan   = byte_rd && (addr == ADDR_W'(OFF_CHAN));
        sel.rd_dio    = byte_rd && (addr == ADDR_W'(OFF_DIO));
        sel.rd_status = byte_rd && (addr == ADDR_W'(OFF_STATUS));
        sel.rd_ctrl   = byte_rd && (addr == ADDR_W'(OFF_CTRL));
        sel.rd_cfg    = byte_rd && (addr == ADDR_W'(OFF_CFG));
    end

    for (genvar gi = 0; gi < NUM_DAC; gi++) begin : g_dac_dec
        localparam logic [ADDR_W-1:0] DAC_OFF =
            ADDR_W'(int'(OFF_DAC_BASE) + DAC_STRIDE * gi);
        assign dac_wr[gi] = word_wr && (addr == DAC_OFF);
        assign dac_rd[gi] = word_rd && (addr == DAC_OFF);
    end

endmodule

// File: rtl/aio_conv_engine.sv
module aio_conv_engine
    import aio_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CHAN_SEL_W-1:0]      chan_first,
    input  logic                       diff_mode,
    input  logic [CH_COUNT*DATA_W-1:0] chan_in,
    output logic                       busy,
    output logic [DATA_W-1:0]          result
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    typedef struct packed {
        logic                  busy;
        logic [CNT_W-1:0]      cnt;
        logic [CHAN_SEL_W-1:0] ch;
        logic [DATA_W-1:0]     result;
    } conv_t;

    conv_t c_d, c_q;
    logic [DATA_W-1:0] picked;

    always_comb begin
        c_d    = c_q;
        picked = chan_in[c_q.ch*DATA_W +: DATA_W];
        if (c_q.busy) begin
            if (c_q.cnt == '0) begin
                c_d.busy   = 1'b0;
                c_d.result = picked + DATA_W'(c_q.ch);
            end else begin
                c_d.cnt = c_q.cnt - 1'b1;
            end
        end else if (start) begin
            c_d.busy = 1'b1;
            c_d.cnt  = CNT_W'(CONV_CYCLES - 1);
            c_d.ch   = diff_mode ? {1'b0, chan_first[CHAN_SEL_W-2:0]} : chan_first;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy   = c_q.busy;
    assign result = c_q.result;

endmodule

// File: rtl/aio_read_mux.sv
module aio_read_mux
    import aio_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_DAC = 2,
    parameter int DIO_W   = 4
) (
    input  aio_sel_t                  sel,
    input  logic [NUM_DAC-1:0]        dac_rd,
    input  logic [7:0]                chan,
    input  logic [CTRL_W-1:0]         ctrl,
    input  logic [CFG_W-1:0]          cfg,
    input  logic [7:0]                status,
    input  logic [DIO_W-1:0]          din,
    input  logic [DATA_W-1:0]         result,
    input  logic [NUM_DAC*DATA_W-1:0] dac,
    output logic [DATA_W-1:0]         rdata
);

    logic [NUM_DAC-1:0][DATA_W-1:0] dac_term;

    for (genvar gi = 0; gi < NUM_DAC; gi++) begin : g_dac_rd
        assign dac_term[gi] = dac_rd[gi] ? dac[gi*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        rdata = '0;
        if (sel.rd_result) rdata = rdata | result;
        if (sel.rd_chan)   rdata = rdata | DATA_W'(chan);
        if (sel.rd_ctrl)   rdata = rdata | DATA_W'(ctrl);
        if (sel.rd_cfg)    rdata = rdata | DATA_W'(cfg);
        if (sel.rd_status) rdata = rdata | DATA_W'(status);
        if (sel.rd_dio)    rdata = rdata | DATA_W'(din);
        for (int k = 0; k < NUM_DAC; k++) rdata = rdata | dac_term[k];
    end

endmodule

// File: rtl/aio_regfile.sv
module aio_regfile
    import aio_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int NUM_DAC     = 2,
    parameter int DIO_W       = 4,
    parameter int CONV_CYCLES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic                       bus_word,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic                       diff_mode,
    input  logic [CH_COUNT*DATA_W-1:0] chan_in,
    input  logic [DIO_W-1:0]           din,
    output logic [DIO_W-1:0]           dout,
    output logic [NUM_DAC*DATA_W-1:0]  dac_out
);

    typedef struct packed {
        logic [7:0]                     chan;
        logic [CTRL_W-1:0]              ctrl;
        logic [CFG_W-1:0]               cfg;
        logic [DIO_W-1:0]               dout;
        logic [NUM_DAC-1:0][DATA_W-1:0] dac;
    } regs_t;

    regs_t r_d, r_q;

    aio_sel_t           sel;
    logic [NUM_DAC-1:0] dac_wr, dac_rd;
    logic               conv_busy;
    logic [DATA_W-1:0]  conv_result;
    logic               conv_go;
    logic [7:0]         status_byte;

    aio_addr_decode #(.ADDR_W(ADDR_W), .NUM_DAC(NUM_DAC)) dec_i (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .word   (bus_word),
        .sel    (sel),
        .dac_wr (dac_wr),
        .dac_rd (dac_rd)
    );

    always_comb begin
        r_d = r_q;
        if (sel.wr_chan) r_d.chan = bus_wdata[7:0];
        if (sel.wr_ctrl) r_d.ctrl = bus_wdata[CTRL_W-1:0];
        if (sel.wr_cfg)  r_d.cfg  = bus_wdata[CFG_W-1:0];
        if (sel.wr_dio)  r_d.dout = bus_wdata[DIO_W-1:0];
        for (int k = 0; k < NUM_DAC; k++) begin
            if (dac_wr[k]) r_d.dac[k] = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign conv_go = sel.wr_strobe && (r_q.ctrl == MODE_SOFT);

    aio_conv_engine #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) conv_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (conv_go),
        .chan_first (r_q.chan[CHAN_SEL_W-1:0]),
        .diff_mode  (diff_mode),
        .chan_in    (chan_in),
        .busy       (conv_busy),
        .result     (conv_result)
    );

    always_comb begin
        status_byte              = '0;
        status_byte[ST_BUSY_BIT] = conv_busy;
        status_byte[ST_DIFF_BIT] = diff_mode;
    end

    aio_read_mux #(.DATA_W(DATA_W), .NUM_DAC(NUM_DAC), .DIO_W(DIO_W)) rmux_i (
        .sel    (sel),
        .dac_rd (dac_rd),
        .chan   (r_q.chan),
        .ctrl   (r_q.ctrl),
        .cfg    (r_q.cfg),
        .status (status_byte),
        .din    (din),
        .result (conv_result),
        .dac    (r_q.dac),
        .rdata  (bus_rdata)
    );

    assign dout    = r_q.dout;
    assign dac_out = r_q.dac;

endmodule

// File: rtl/aio_regfile_chk.sv
module aio_regfile_chk #(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int NUM_DAC     = 2,
    parameter int DIO_W       = 4,
    parameter int CONV_CYCLES = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic                      bus_word,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      busy,
    input logic [DIO_W-1:0]          dout,
    input logic [NUM_DAC*DATA_W-1:0] dac_out
);

    localparam int CW = $clog2(CONV_CYCLES + 1) + 1;
    logic [CW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    // R4: busy starts only after a byte write to the strobe offset
    assert_start_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && !bus_word && bus_addr == '0));

    // R4 / R6: busy lasts exactly CONV_CYCLES cycles, extra strobes do not stretch it
    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == CW'(CONV_CYCLES));

    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_len < CW'(CONV_CYCLES));

    // R10: digital outputs move only after a byte write at the port offset
    assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr && !bus_word && bus_addr == ADDR_W'(3)) |-> $stable(dout));

    // R2: each DAC code moves only after a word write at its own offset
    for (genvar gi = 0; gi < NUM_DAC; gi++) begin : g_dac_chk
        assert_dac_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(bus_wr && bus_word && bus_addr == ADDR_W'(4 + 2 * gi))
            |-> $stable(dac_out[gi*DATA_W +: DATA_W]));
    end

    // R12: the read bus is quiet whenever no read is presented
    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

endmodule

bind aio_regfile aio_regfile_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DAC(NUM_DAC),
    .DIO_W(DIO_W), .CONV_CYCLES(CONV_CYCLES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_word  (bus_word),
    .bus_rdata (bus_rdata),
    .busy      (conv_busy),
    .dout      (dout),
    .dac_out   (dac_out)
);

// File: tb/aio_regfile_tb_top.sv
`timescale 1ns/1ps
module aio_regfile_tb_top;

    localparam int LAT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        diff_mode = 1'b0;
    logic [255:0] chan_in;
    logic [3:0]  din = '0;
    logic [3:0]  dout;
    logic [31:0] dac_out;
    logic [15:0] ain [16];

    int vecs = 0;
    int fails = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 16; k++) chan_in[k*16 +: 16] = ain[k];
    end

    aio_regfile #(.CONV_CYCLES(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .diff_mode(diff_mode), .chan_in(chan_in),
        .din(din), .dout(dout), .dac_out(dac_out)
    );

    // monitor: pops the expected read value and compares mid-cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            vecs++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: read with no expectation, got %h expected none", bus_rdata);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    function automatic logic [15:0] sample(int ch, bit diff);
        int c;
        c = diff ? (ch & 7) : (ch & 15);
        return ain[c] + 16'(c);
    endfunction

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [4:0] a, bit w, logic [15:0] d);
        bus_addr = a; bus_word = w; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, bit w, logic [15:0] e, string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_word = w; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk(string t, logic [31:0] act, logic [31:0] e);
        vecs++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        for (int k = 0; k < 15; k++) ain[k] = 16'h1111 * 16'(k) + 16'h0101;
        ain[15] = 16'hFFFF;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(5'h02, 0, 16'h0000, "R1 chan");
        rd(5'h09, 0, 16'h0000, "R1 ctrl");
        rd(5'h11, 0, 16'h0000, "R1 cfg");
        rd(5'h08, 0, 16'h0000, "R1 status");
        rd(5'h04, 1, 16'h0000, "R1 dac0");
        rd(5'h06, 1, 16'h0000, "R1 dac1");
        rd(5'h00, 1, 16'h0000, "R1 result");
        chk("R1 dout", 32'(dout), 32'h0);
        chk("R1 dac_out", dac_out, 32'h0);

        // R2 DAC codes
        wr(5'h04, 1, 16'hBEEF);
        wr(5'h06, 1, 16'h1234);
        chk("R2 dac_out", dac_out, 32'h1234_BEEF);
        rd(5'h04, 1, 16'hBEEF, "R2 dac0");
        rd(5'h06, 1, 16'h1234, "R2 dac1");

        // R3 R4 R5 basic conversion on channel 3
        wr(5'h02, 0, 16'h0073);
        rd(5'h02, 0, 16'h0073, "R3 chan readback");
        wr(5'h00, 0, 16'h00A5);
        idle(LAT - 1);
        rd(5'h08, 0, 16'h0080, "R4 busy last cycle");
        rd(5'h08, 0, 16'h0000, "R5 busy cleared");
        rd(5'h00, 1, sample(3, 0), "R5 result ch3");

        // R5 wrap on channel 15
        wr(5'h02, 0, 16'h00FF);
        wr(5'h00, 0, 16'h0000);
        idle(LAT);
        rd(5'h00, 1, sample(15, 0), "R5 result wrap ch15");

        // R6 strobe while busy ignored
        wr(5'h02, 0, 16'h0022);
        wr(5'h00, 0, 16'h0001);
        idle(2);
        wr(5'h02, 0, 16'h0055);
        wr(5'h00, 0, 16'h0001);
        idle(LAT - 5);
        rd(5'h08, 0, 16'h0080, "R6 busy not extended (still busy)");
        rd(5'h08, 0, 16'h0000, "R6 busy not extended (cleared)");
        rd(5'h00, 1, sample(2, 0), "R6 channel kept");
        rd(5'h02, 0, 16'h0055, "R3 chan write while busy");

        // R7 non-software mode blocks strobe
        wr(5'h09, 0, 16'h00FD);
        rd(5'h09, 0, 16'h0001, "R7 ctrl readback");
        wr(5'h00, 0, 16'h0000);
        rd(5'h08, 0, 16'h0000, "R7 no start in mode 1");
        idle(LAT);
        rd(5'h00, 1, sample(2, 0), "R7 result unchanged");
        wr(5'h09, 0, 16'h0000);

        // R8 configuration
        wr(5'h11, 0, 16'h00FF);
        rd(5'h11, 0, 16'h0007, "R8 cfg masked");
        wr(5'h11, 0, 16'h0002);
        rd(5'h11, 0, 16'h0002, "R8 gain x4 code");

        // R9 differential mode
        diff_mode = 1'b1;
        rd(5'h08, 0, 16'h0020, "R9 diff flag");
        wr(5'h02, 0, 16'h000D);
        wr(5'h00, 0, 16'h0000);
        idle(LAT - 1);
        rd(5'h08, 0, 16'h00A0, "R9 busy with diff flag");
        rd(5'h08, 0, 16'h0020, "R9 idle with diff flag");
        rd(5'h00, 1, sample(13, 1), "R9 diff channel ch5");

        // R10 digital I/O
        din = 4'hA;
        rd(5'h03, 0, 16'h000A, "R10 din");
        wr(5'h03, 0, 16'h00F5);
        chk("R10 dout", 32'(dout), 32'h5);

        // R11 width mismatch
        wr(5'h02, 1, 16'h0077);
        rd(5'h02, 0, 16'h000D, "R11 word write to byte reg ignored");
        wr(5'h04, 0, 16'h0011);
        chk("R11 byte write to dac ignored", dac_out, 32'h1234_BEEF);
        rd(5'h04, 0, 16'h0000, "R11 byte read of dac");
        rd(5'h02, 1, 16'h0000, "R11 word read of byte reg");
        rd(5'h00, 0, 16'h0000, "R11 byte read at result");
        wr(5'h00, 1, 16'h0000);
        rd(5'h08, 0, 16'h0020, "R11 word write at strobe no start");

        // R12 undefined / read-only
        wr(5'h08, 0, 16'h00FF);
        rd(5'h08, 0, 16'h0020, "R12 status read-only");
        wr(5'h01, 0, 16'h00FF);
        rd(5'h01, 0, 16'h0000, "R12 undefined offset 1");
        rd(5'h10, 0, 16'h0000, "R12 undefined offset 0x10");
        chk("R12 dout untouched", 32'(dout), 32'h5);

        idle(2);
        summary();
    end

endmodule